// File: doc/BRIEF.md
# Shared event interrupt pending and priority vector

This block gathers twenty event interrupt sources that share one request line into the main interrupt controller. There are six capture/compare channel events, ten overrun events, two compare events and two timer overflow events. Each one-cycle event pulse latches a pending bit. Software sees the pending bits through a 16-bit view and an 8-bit view. It services the sources through a priority vector, which returns a code for the highest-priority enabled pending source.

A read of the vector acknowledges the source it reports by clearing only that source's pending bit, in the same clock edge that samples the code. The returned code and the cleared bit therefore always refer to the same source. A per-source enable mask decides which pending bits take part in the vector and in the summary request. Pending bits latch whether or not their source is enabled, so a disabled source can still be polled.

Read data is registered and appears on `rdata_o` one cycle after the read strobe. It holds that value until the next read.

Top module: `evt_irq_mux`

## Requirements
- R1: A high cycle on `evt_i[k]` sets pending bit k at the next clock edge. The layout of `evt_i` and of the pending state is as follows. Bits 19:14 are channel events 4 to 9, with channel 4 in bit 19. Bits 13:4 are overrun events 0 to 9, with overrun 0 in bit 13. Bit 3 is compare 0, bit 2 is compare 1, bit 1 is timer 1 overflow and bit 0 is timer 2 overflow. A pending bit is set only by its event.
- R2: A read with `addr_i`=0 returns pending bits 19:4 on `rdata_o[15:0]`. A read with `addr_i`=1 returns pending bits 3:0 on `rdata_o[3:0]`, with bits 15:4 zero. A read with `addr_i`=3 returns zero. In every case the data is valid on the cycle after `rd_en_i`.
- R3: After reset all pending bits, `rdata_o` and `irq_o` are zero.
- R4: A read with `addr_i`=2 returns the vector code 20−k, where k is the highest-numbered pending bit whose `mask_i` bit is 1. The code is therefore 1 for bit 19 and 20 for bit 0. It returns 0 when no enabled bit is pending.
- R5: A vector read that returns a nonzero code clears exactly the pending bit that code names, at the same edge. All other pending bits keep their value.
- R6: A pending bit whose `mask_i` bit is 0 still latches and still reads back at addresses 0 and 1. It is ignored by the vector and by `irq_o`.
- R7: If an event and a vector-read clear hit the same bit in the same cycle, the bit stays set.
- R8: `irq_o` is high exactly when some pending bit with its `mask_i` bit set is 1. It follows the pending state with no further delay.
- R9: Reads at addresses 0, 1 and 3 change no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 20 | One-cycle event pulses, one per source |
| mask_i | input | 20 | Per-source enable for vector and request (1 = enabled) |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 2 | Read address: 0 wide pending, 1 narrow pending, 2 vector, 3 reserved |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Summary request to the main interrupt controller |

## Verification
The event set and the vector-read clear can land on the same pending bit in the same cycle. The bench provokes this by driving the event for the bit that currently wins arbitration during the cycle of the vector read strobe. It also repeats the case with an event on a different bit. The outcome is judged through the returned code and through a second vector read. That read must report the same source again when the event and the clear hit the same bit, and it must report the newly set source when they hit different bits.

// File: rtl/evt_irq_pkg.sv
`timescale 1ns/1ps
package evt_irq_pkg;
  localparam int unsigned N_WIDE   = 16;
  localparam int unsigned N_NARROW = 4;
  localparam int unsigned N_SRC    = N_WIDE + N_NARROW;
  localparam int unsigned CODE_W   = $clog2(N_SRC + 1);
  localparam int unsigned DATA_W   = 16;

  typedef enum logic [1:0] {
    ADDR_WIDE   = 2'd0,
    ADDR_NARROW = 2'd1,
    ADDR_VEC    = 2'd2,
    ADDR_RSVD   = 2'd3
  } rd_addr_e;
endpackage

// File: rtl/evt_pend_bank.sv
`timescale 1ns/1ps
module evt_pend_bank #(
  parameter int unsigned N = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    // set beats clear so a colliding event is kept
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pend_o[i] <= 1'b0;
      else if (set_i[i])  pend_o[i] <= 1'b1;
      else if (clr_i[i])  pend_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_prio_enc.sv
`timescale 1ns/1ps
module evt_prio_enc #(
  parameter int unsigned N      = 20,
  parameter int unsigned CODE_W = $clog2(N + 1)
) (
  input  logic [N-1:0]      req_i,
  output logic [N-1:0]      grant_o,
  output logic [CODE_W-1:0] code_o
);
  // ascending scan; the highest set index is the last to assign
  always_comb begin
    grant_o = '0;
    code_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        code_o     = CODE_W'(N - i);
      end
    end
  end
endmodule

// File: rtl/evt_rd_mux.sv
`timescale 1ns/1ps
module evt_rd_mux
  import evt_irq_pkg::*;
#(
  parameter int unsigned N_HI   = 16,
  parameter int unsigned N_LO   = 4,
  parameter int unsigned CODE_W = 5,
  parameter int unsigned DW     = 16,
  localparam int unsigned N     = N_HI + N_LO
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  rd_addr_e          addr_i,
  input  logic [N-1:0]      pend_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [DW-1:0]     rdata_o
);
  logic [DW-1:0] sel;

  always_comb begin
    unique case (addr_i)
      ADDR_WIDE:   sel = DW'(pend_i[N-1 -: N_HI]);
      ADDR_NARROW: sel = DW'(pend_i[N_LO-1:0]);
      ADDR_VEC:    sel = DW'(code_i);
      default:     sel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= sel;
  end
endmodule

// File: rtl/evt_irq_mux.sv
`timescale 1ns/1ps
module evt_irq_mux
  import evt_irq_pkg::*;
#(
  parameter int unsigned N_HI = N_WIDE,
  parameter int unsigned N_LO = N_NARROW,
  parameter int unsigned DW   = DATA_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_HI+N_LO-1:0]   evt_i,
  input  logic [N_HI+N_LO-1:0]   mask_i,
  input  logic                   rd_en_i,
  input  logic [1:0]             addr_i,
  output logic [DW-1:0]          rdata_o,
  output logic                   irq_o
);
  localparam int unsigned N_SRC_L  = N_HI + N_LO;
  localparam int unsigned CODE_W_L = $clog2(N_SRC_L + 1);

  logic [N_SRC_L-1:0]  pend_q;
  logic [N_SRC_L-1:0]  req;
  logic [N_SRC_L-1:0]  grant;
  logic [N_SRC_L-1:0]  clr_vec;
  logic [CODE_W_L-1:0] vec_code;
  logic                vec_rd;
  rd_addr_e            addr;

  assign addr    = rd_addr_e'(addr_i);
  assign req     = pend_q & mask_i;
  assign vec_rd  = rd_en_i && (addr == ADDR_VEC);
  assign clr_vec = vec_rd ? grant : '0;
  assign irq_o   = |req;

  evt_pend_bank #(.N(N_SRC_L)) i_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_i),
    .clr_i  (clr_vec),
    .pend_o (pend_q)
  );

  evt_prio_enc #(.N(N_SRC_L), .CODE_W(CODE_W_L)) i_enc (
    .req_i   (req),
    .grant_o (grant),
    .code_o  (vec_code)
  );

  evt_rd_mux #(.N_HI(N_HI), .N_LO(N_LO), .CODE_W(CODE_W_L), .DW(DW)) i_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_en_i),
    .addr_i  (addr),
    .pend_i  (pend_q),
    .code_i  (vec_code),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/evt_irq_chk.sv
`timescale 1ns/1ps
module evt_irq_chk #(
  parameter int unsigned N      = 20,
  parameter int unsigned CODE_W = 5,
  parameter int unsigned DW     = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N-1:0]      evt_i,
  input logic              rd_en_i,
  input logic [1:0]        addr_i,
  input logic [DW-1:0]     rdata_o,
  input logic              irq_o,
  input logic [N-1:0]      pend_q,
  input logic [N-1:0]      clr_vec,
  input logic [CODE_W-1:0] vec_code
);
  AST_EVT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((pend_q & $past(evt_i)) == $past(evt_i))); // R1

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(evt_i)) == '0)); // R1

  AST_NARROW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 2'd1) |=> (rdata_o[DW-1:4] == '0)); // R2

  AST_CLR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_vec)); // R5

  AST_OTHERS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend_q) & ~$past(clr_vec) & ~pend_q) == '0)); // R5

  AST_CODE_RETURNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 2'd2) |=> (rdata_o == DW'($past(vec_code)))); // R4

  AST_CLR_APPLIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_vec != '0) |=> ((pend_q & $past(clr_vec) & ~$past(evt_i)) == '0)); // R5

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_vec & evt_i) != '0) |=> ((pend_q & $past(clr_vec & evt_i)) != '0)); // R7

  AST_IRQ_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (vec_code != '0)); // R8
endmodule

bind evt_irq_mux evt_irq_chk #(.N(N_SRC_L), .CODE_W(CODE_W_L), .DW(DW)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .evt_i    (evt_i),
  .rd_en_i  (rd_en_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .pend_q   (pend_q),
  .clr_vec  (clr_vec),
  .vec_code (vec_code)
);

// File: tb/test_evt_irq_mux.sv
`timescale 1ns/1ps
module test_evt_irq_mux;
  localparam int N = 20;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  evt_i = '0;
  logic [N-1:0]  mask_i = '1;
  logic          rd_en_i = 1'b0;
  logic [1:0]    addr_i = 2'd0;
  logic [15:0]   rdata_o;
  logic          irq_o;

  int errors = 0;
  int checks = 0;
  logic [N-1:0] model = '0;
  logic [15:0]  exp_rd;
  bit done = 0;

  always #2.5 clk = ~clk;

  evt_irq_mux i_evt_irq_mux (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt_i), .mask_i(mask_i),
    .rd_en_i(rd_en_i), .addr_i(addr_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic int exp_code(logic [N-1:0] p);
    int c = 0;
    for (int i = 0; i < N; i++) if (p[i]) c = N - i;
    return c;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive after negedge, update model at posedge, sample at next negedge
  task automatic step(logic [N-1:0] ev, logic rd, logic [1:0] ad, string req);
    int c;
    evt_i = ev; rd_en_i = rd; addr_i = ad;
    @(posedge clk);
    c = exp_code(model & mask_i);
    case (ad)
      2'd0:    exp_rd = model[19:4];
      2'd1:    exp_rd = 16'(model[3:0]);
      2'd2:    exp_rd = 16'(c);
      default: exp_rd = '0;
    endcase
    if (rd && ad == 2'd2 && c != 0) model[N - c] = 1'b0;
    model = model | ev;
    @(negedge clk);
    evt_i = '0; rd_en_i = 1'b0;
    if (rd) chk(req, 32'(rdata_o), 32'(exp_rd));
    chk("R8", 32'(irq_o), 32'(|(model & mask_i)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R3", 32'(irq_o), 0);
    chk("R3", 32'(rdata_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) step('0, 1'b1, 2'(a), "R3");

    // single-source sweep: layout, code, clear
    for (int k = 0; k < N; k++) begin
      step(N'(1) << k, 1'b0, 2'd0, "R1");
      step('0, 1'b1, 2'd0, "R1");
      step('0, 1'b1, 2'd1, "R2");
      step('0, 1'b1, 2'd3, "R2");
      step('0, 1'b1, 2'd2, "R4");
      step('0, 1'b1, 2'd2, "R5");
    end

    // full priority walk
    step('1, 1'b0, 2'd0, "R1");
    for (int k = 0; k <= N; k++) begin
      step('0, 1'b1, 2'd2, "R4");
      step('0, 1'b1, 2'd0, "R5");
      step('0, 1'b1, 2'd1, "R5");
    end

    // side-effect-free reads
    step(20'h5A5A5, 1'b0, 2'd0, "R1");
    for (int r = 0; r < 3; r++) begin
      step('0, 1'b1, 2'd0, "R9");
      step('0, 1'b1, 2'd1, "R9");
      step('0, 1'b1, 2'd3, "R9");
    end
    step('0, 1'b1, 2'd0, "R9");

    // mask sweep: each enabled alone picks its own bit
    step('1, 1'b0, 2'd0, "R1");
    for (int k = 0; k < N; k++) begin
      mask_i = N'(1) << k;
      step('0, 1'b1, 2'd2, "R6");
      step('0, 1'b1, 2'd0, "R6");
      step('0, 1'b1, 2'd1, "R6");
    end

    // all masked: latched but silent
    mask_i = '0;
    step(20'h80001, 1'b0, 2'd0, "R6");
    step('0, 1'b1, 2'd2, "R6");
    step('0, 1'b1, 2'd0, "R6");
    step('0, 1'b1, 2'd1, "R6");
    mask_i = '1;
    @(negedge clk);
    chk("R8", 32'(irq_o), 1);
    while (model != 0) step('0, 1'b1, 2'd2, "R5");

    // collision on the same bit, then on a different bit
    step(N'(1) << 19, 1'b0, 2'd0, "R1");
    step(N'(1) << 19, 1'b1, 2'd2, "R7");
    step('0, 1'b1, 2'd2, "R7");
    step(N'(1) << 19, 1'b0, 2'd0, "R1");
    step(N'(1) << 5, 1'b1, 2'd2, "R7");
    step('0, 1'b1, 2'd2, "R7");
    step('0, 1'b1, 2'd2, "R5");
    for (int k = 0; k < N; k += 3) begin
      step(N'(1) << k, 1'b0, 2'd0, "R1");
      step(N'(1) << k, 1'b1, 2'd2, "R7");
      step('0, 1'b1, 2'd2, "R7");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule